// File: doc/BRIEF.md
# Vertical Blanking Pulse Generator

This block derives a vertical blanking level from a stream of line-rate strobes. A line counter advances by one on every strobe, and the output goes high or low when the counter reaches one of two programmed positions. The counter runs through a frame of 262 lines and then starts again from zero.

Software programs the two positions through a small register write port. One register holds the rising-edge position and the other holds the falling-edge position, both in units of two lines. The output is a plain level that can feed an interrupt source. When both positions hold the same value, the generator freezes: the counter does not move and the output keeps its level.

Top module: `vbp_gen`

## Requirements
- R1: While reset is asserted, `vs_o` is 0, the line count is 0 and both positions are 0. After reset, the first strobe produces an incremented count of 1.
- R2: A write with `wr_addr_i` = 0x2E loads `wr_data_i` into the rise position. A write with `wr_addr_i` = 0x2F loads it into the fall position. A write to any other address changes neither position.
- R3: The line count advances by exactly one on each cycle with `tick_i` high, provided the positions differ. Without a strobe, neither the count nor `vs_o` changes.
- R4: On a counting strobe whose incremented count equals twice the rise position, `vs_o` is 1 from the following cycle.
- R5: On a counting strobe whose incremented count equals twice the fall position, `vs_o` is 0 from the following cycle.
- R6: When the incremented count reaches 262, the count becomes 0, so one frame is exactly 262 strobes long. An incremented value of 262 matches no position.
- R7: While both positions hold equal values, a strobe leaves both the count and `vs_o` unchanged.
- R8: A position whose doubled value is 262 or more, or a position of 0, never produces an edge.
- R9: A strobe in the same cycle as a register write is judged against the position values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Line strobe, one clock cycle wide |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| vs_o | output | 1 | Vertical blanking level |

## Verification
A register write and a line strobe can land in the same clock cycle. When that write also makes the two positions equal, it stops the counter from the next strobe onward. The bench provokes this by raising `tick_i` together with a write of the rise position at the moment the old rise position matches. It expects `vs_o` to go high on that edge. It then checks that later strobes move nothing, by showing that the fall edge arrives at the count the frozen value predicts.

// File: rtl/vbp_pkg.sv
package vbp_pkg;

   localparam int unsigned VBP_REG_W  = 8;
   localparam int unsigned VBP_ADDR_W = 8;
   localparam int unsigned VBP_CNT_W  = 9;
   localparam int unsigned VBP_WRAP   = 262;
   localparam int unsigned VBP_SCALE  = 2;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_RISE = 2'd1,
      SEL_FALL = 2'd2
   } vbp_sel_e;

   localparam int unsigned EDGE_RISE = 0;
   localparam int unsigned EDGE_FALL = 1;
   localparam int unsigned EDGE_N    = 2;

endpackage

// File: rtl/vbp_regs.sv
module vbp_regs
   import vbp_pkg::*;
#(
   parameter int unsigned REG_W     = VBP_REG_W,
   parameter int unsigned ADDR_W    = VBP_ADDR_W,
   parameter logic [ADDR_W-1:0] RISE_ADDR = 'h2E,
   parameter logic [ADDR_W-1:0] FALL_ADDR = 'h2F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rise_pos,
   output logic [REG_W-1:0]  fall_pos
);

   if (RISE_ADDR == FALL_ADDR) begin : g_bad_map
      $error("vbp_regs: rise and fall addresses must differ");
   end

   vbp_sel_e sel;

   always_comb begin
      sel = SEL_NONE;
      if (wr_en) begin
         if (wr_addr == RISE_ADDR)      sel = SEL_RISE;
         else if (wr_addr == FALL_ADDR) sel = SEL_FALL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_pos <= '0;
         fall_pos <= '0;
      end else begin
         case (sel)
            SEL_RISE: rise_pos <= wr_data;
            SEL_FALL: fall_pos <= wr_data;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/vbp_line_ctr.sv
module vbp_line_ctr
   import vbp_pkg::*;
#(
   parameter int unsigned CNT_W = VBP_CNT_W,
   parameter int unsigned WRAP  = VBP_WRAP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_inc
);

   localparam logic [CNT_W-1:0] WRAP_V = CNT_W'(WRAP);

   if (WRAP < 2 || WRAP >= (2 ** CNT_W)) begin : g_bad_wrap
      $error("vbp_line_ctr: WRAP must fit below 2**CNT_W");
   end

   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      cnt_inc = cnt + CNT_W'(1);
      cnt_nxt = (cnt_inc == WRAP_V) ? '0 : cnt_inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= cnt_nxt;
   end

endmodule

// File: rtl/vbp_edge_cmp.sv
module vbp_edge_cmp
   import vbp_pkg::*;
#(
   parameter int unsigned REG_W = VBP_REG_W,
   parameter int unsigned CNT_W = VBP_CNT_W,
   parameter int unsigned SCALE = VBP_SCALE,
   parameter int unsigned WRAP  = VBP_WRAP
) (
   input  logic             step,
   input  logic [CNT_W-1:0] cnt_inc,
   input  logic [REG_W-1:0] pos,
   output logic             hit
);

   localparam int unsigned SH    = (SCALE > 1) ? $clog2(SCALE) : 0;
   localparam int unsigned CMP_W = REG_W + SH + 1;
   localparam int unsigned MW    = (CMP_W > CNT_W) ? CMP_W : CNT_W;
   localparam bit          POW2  = ((SCALE & (SCALE - 1)) == 0);

   if (SCALE == 0) begin : g_bad_scale
      $error("vbp_edge_cmp: SCALE must be at least 1");
   end

   logic [MW-1:0] target;

   if (POW2) begin : g_shift
      assign target = MW'(pos) << SH;
   end else begin : g_mult
      assign target = MW'(pos) * MW'(SCALE);
   end

   logic in_frame;

   always_comb begin
      in_frame = (target < MW'(WRAP));
      hit      = step && in_frame && (MW'(cnt_inc) == target);
   end

endmodule

// File: rtl/vbp_gen.sv
module vbp_gen
   import vbp_pkg::*;
#(
   parameter int unsigned REG_W  = VBP_REG_W,
   parameter int unsigned ADDR_W = VBP_ADDR_W,
   parameter int unsigned CNT_W  = VBP_CNT_W,
   parameter int unsigned WRAP   = VBP_WRAP,
   parameter int unsigned SCALE  = VBP_SCALE,
   parameter logic [ADDR_W-1:0] RISE_ADDR = 'h2E,
   parameter logic [ADDR_W-1:0] FALL_ADDR = 'h2F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [REG_W-1:0]  wr_data_i,
   output logic              vs_o
);

   logic [REG_W-1:0] rise_pos;
   logic [REG_W-1:0] fall_pos;
   logic [CNT_W-1:0] line_cnt;
   logic [CNT_W-1:0] line_inc;
   logic             step;
   logic [EDGE_N-1:0] edge_hit;
   logic [REG_W-1:0] edge_pos [EDGE_N];

   vbp_regs #(
      .REG_W(REG_W), .ADDR_W(ADDR_W),
      .RISE_ADDR(RISE_ADDR), .FALL_ADDR(FALL_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
      .rise_pos(rise_pos), .fall_pos(fall_pos)
   );

   assign step = tick_i && (rise_pos != fall_pos);

   vbp_line_ctr #(
      .CNT_W(CNT_W), .WRAP(WRAP)
   ) u_ctr (
      .clk(clk), .rst_n(rst_n), .step(step),
      .cnt(line_cnt), .cnt_inc(line_inc)
   );

   assign edge_pos[EDGE_RISE] = rise_pos;
   assign edge_pos[EDGE_FALL] = fall_pos;

   for (genvar e = 0; e < EDGE_N; e++) begin : g_edge
      vbp_edge_cmp #(
         .REG_W(REG_W), .CNT_W(CNT_W), .SCALE(SCALE), .WRAP(WRAP)
      ) u_cmp (
         .step(step), .cnt_inc(line_inc),
         .pos(edge_pos[e]), .hit(edge_hit[e])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   vs_o <= 1'b0;
      else if (edge_hit[EDGE_FALL]) vs_o <= 1'b0;
      else if (edge_hit[EDGE_RISE]) vs_o <= 1'b1;
   end

endmodule

// File: rtl/vbp_gen_chk.sv
module vbp_gen_chk #(
   parameter int unsigned REG_W  = 8,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CNT_W  = 9,
   parameter int unsigned WRAP   = 262,
   parameter int unsigned SCALE  = 2,
   parameter logic [ADDR_W-1:0] RISE_ADDR = 'h2E,
   parameter logic [ADDR_W-1:0] FALL_ADDR = 'h2F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic              vs_o,
   input logic [CNT_W-1:0]  line_cnt,
   input logic [REG_W-1:0]  rise_pos,
   input logic [REG_W-1:0]  fall_pos
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(WRAP - 1);

   // R3: no strobe, nothing moves
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(line_cnt) && $stable(vs_o));

   // R3: a counting strobe adds one below the last line
   a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && rise_pos != fall_pos && line_cnt != LAST)
      |=> line_cnt == $past(line_cnt) + CNT_W'(1));

   // R6: last line wraps to zero and count stays inside the frame
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && rise_pos != fall_pos && line_cnt == LAST) |=> line_cnt == '0);

   a_r6_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      line_cnt < CNT_W'(WRAP));

   // R7: equal positions freeze everything
   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && rise_pos == fall_pos) |=> $stable(line_cnt) && $stable(vs_o));

   // R4 and R8: a rise needs a strobe and an in-frame rise position
   a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vs_o) |-> $past(tick_i) && ($past(int'(rise_pos)) * int'(SCALE) < int'(WRAP))
                      && ($past(rise_pos) != '0));

   // R5: a fall needs a strobe
   a_r5_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vs_o) |-> $past(tick_i));

   // R2: stray addresses leave both positions alone
   a_r2_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i || (wr_addr_i != RISE_ADDR && wr_addr_i != FALL_ADDR))
      |=> $stable(rise_pos) && $stable(fall_pos));

endmodule

bind vbp_gen vbp_gen_chk #(
   .REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WRAP(WRAP), .SCALE(SCALE),
   .RISE_ADDR(RISE_ADDR), .FALL_ADDR(FALL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
   .wr_addr_i(wr_addr_i), .vs_o(vs_o), .line_cnt(line_cnt),
   .rise_pos(rise_pos), .fall_pos(fall_pos)
);

// File: tb/vbp_gen_test.sv
module vbp_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [7:0] wr_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic       vs_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   vbp_gen uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .vs_o(vs_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_vs(input string req, input logic exp);
      check(vs_o === exp, req, int'(vs_o), int'(exp));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      tick_i = 1'b0;
      wr_en_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         tick_i = 1'b1;
         @(negedge clk);
      end
      tick_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      check_vs("R1 vs low in reset", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_vs("R1 vs low after reset", 1'b0);
   endtask

   task automatic t_basic_pulse();
      do_reset();
      wr(8'h2E, 8'd1);
      wr(8'h2F, 8'd3);
      pulse(1);
      check_vs("R1 count starts at zero, no edge at 1", 1'b0);
      pulse(1);
      check_vs("R4 rise at count 2", 1'b1);
      idle(10);
      pulse(3);
      check_vs("R3 idle cycles do not advance count", 1'b1);
      pulse(1);
      check_vs("R5 fall at count 6", 1'b0);
      pulse(257);
      check_vs("R6 no rise before wrap completes", 1'b0);
      pulse(1);
      check_vs("R6 rise after 262-line frame", 1'b1);
      pulse(4);
      check_vs("R6 fall one frame later", 1'b0);
   endtask

   task automatic t_stray_writes();
      do_reset();
      wr(8'h2E, 8'd2);
      wr(8'h2F, 8'd4);
      wr(8'h2C, 8'd1);
      wr(8'hAE, 8'd1);
      wr(8'hAF, 8'd1);
      pulse(3);
      check_vs("R2 stray write did not move rise", 1'b0);
      pulse(1);
      check_vs("R2 rise at programmed position", 1'b1);
      pulse(4);
      check_vs("R2 stray write did not move fall", 1'b0);
   endtask

   task automatic t_equal_freeze();
      do_reset();
      wr(8'h2E, 8'd2);
      wr(8'h2F, 8'd2);
      pulse(10);
      check_vs("R7 equal positions give no edge", 1'b0);
      wr(8'h2F, 8'd5);
      pulse(3);
      check_vs("R7 count was frozen at zero", 1'b0);
      pulse(1);
      check_vs("R7 rise at 4 after unfreeze", 1'b1);
      wr(8'h2F, 8'd2);
      pulse(20);
      check_vs("R7 frozen keeps vs high", 1'b1);
      wr(8'h2F, 8'd5);
      pulse(5);
      check_vs("R7 count held at 4 while frozen", 1'b1);
      pulse(1);
      check_vs("R5 fall at 10", 1'b0);
   endtask

   task automatic t_out_of_frame();
      int bad;
      do_reset();
      wr(8'h2E, 8'd131);
      wr(8'h2F, 8'd0);
      bad = 0;
      for (int i = 0; i < 300; i++) begin
         pulse(1);
         if (vs_o !== 1'b0) bad++;
      end
      check(bad == 0, "R8 position 131 never rises", bad, 0);
      do_reset();
      wr(8'h2E, 8'd130);
      wr(8'h2F, 8'd131);
      pulse(259);
      check_vs("R8 no rise before 260", 1'b0);
      pulse(1);
      check_vs("R8 rise at 260", 1'b1);
      pulse(340);
      check_vs("R8 fall position 131 never clears", 1'b1);
   endtask

   task automatic t_write_with_tick();
      do_reset();
      wr(8'h2E, 8'd1);
      wr(8'h2F, 8'd3);
      pulse(1);
      tick_i = 1'b1;
      wr_en_i = 1'b1; wr_addr_i = 8'h2E; wr_data_i = 8'd3;
      @(negedge clk);
      tick_i = 1'b0;
      wr_en_i = 1'b0;
      check_vs("R9 strobe used old rise position", 1'b1);
      pulse(5);
      check_vs("R9 new equal positions freeze", 1'b1);
      wr(8'h2F, 8'd4);
      pulse(5);
      check_vs("R9 count held at 2", 1'b1);
      pulse(1);
      check_vs("R9 fall at 8", 1'b0);
   endtask

   initial begin
      t_reset_state();
      t_basic_pulse();
      t_stray_writes();
      t_equal_freeze();
      t_out_of_frame();
      t_write_with_tick();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule